// File: doc/BRIEF.md
# Width-Adapting Static Memory Read Controller

This controller takes single read requests from a processor and serves them from external static memory banks such as ROM or NOR flash. Eight banks share one address window, and address bits 29:27 pick the bank. Each bank is set to an 8-, 16- or 32-bit data path. The controller turns the processor byte address into a device word address, which depends on the bank's width. It then runs one, two or four device reads. The processor address bits that are not wired to the device either choose a byte lane in the returned data or advance the device address from one read to the next. The result comes back right-aligned, together with a one-cycle done strobe.

The sequencer has three states. IDLE waits for a request. ACCESS drives the chip-select and the output-enable for each device read. FINISH presents the result for one cycle. IDLE moves to ACCESS when an aligned request is accepted. IDLE moves straight to FINISH when the request is misaligned or has the reserved size code. ACCESS stays in ACCESS from one device read to the next, and moves to FINISH after the final wait cycle of the last read. FINISH always returns to IDLE.

Top module: `stmem_read_ctrl`

## Requirements
- R1: While reset is held and after it is released, all chip-selects and the output-enable are high, and `rsp_done` and `rsp_err` are low.
- R2: Address bits 29:27 choose bank k, and only `mem_cs_n[k]` goes low. The bank's width comes from `cfg_width[2k+1:2k]`: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit, and 11 is treated as 32-bit.
- R3: The first device address is the in-bank byte address (bits 26:0) shifted right by 0, 1 or 2 places for 8-, 16- or 32-bit banks.
- R4: The number of device reads is 1, 2 or 4 for a byte, halfword or word read on an 8-bit bank. It is 1, 1 or 2 on a 16-bit bank, and always 1 on a 32-bit bank. Successive reads use consecutive device addresses.
- R5: Each device read holds its chip-select and output-enable low, with a stable address, for `cfg_wait`+1 cycles. The data is sampled in the last of those cycles.
- R6: A byte read from a 16-bit bank takes device bits 7:0 when address bit 0 is 0, and bits 15:8 when it is 1. On a 32-bit bank it takes device bits 8n+7:8n, where n is address bits 1:0.
- R7: A word read from narrow devices is packed little-endian: the byte at the lowest address goes to `rsp_data[7:0]`.
- R8: Size codes are 00 byte, 01 halfword, 10 word. A halfword result fills `rsp_data[15:0]` from bytes addr and addr+1, and its upper bits are zero. A byte result is zero-extended from bit 8.
- R9: A halfword read with address bit 0 set, a word read with address bits 1:0 not zero, or size code 11 gives `rsp_done` and `rsp_err` in the cycle after acceptance, with no device read.
- R10: `rsp_done` is high for exactly one cycle per accepted request. The latency is reads×(`cfg_wait`+1)+1 cycles from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, sampled in IDLE |
| req_addr | input | 32 | Processor byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cfg_width | input | 16 | Two-bit width code per bank |
| cfg_wait | input | 3 | Wait cycles per device read, minus one |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Alignment or size error, valid with done |
| rsp_data | output | 32 | Right-aligned read result |
| mem_cs_n | output | 8 | Active-low bank chip-selects |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_addr | output | 27 | Device word address |
| mem_rdata | input | 32 | Device read data |

## Verification
The assertions check every cycle that at most one chip-select is low and that the output-enable goes low only together with it. They also check that the device address holds steady during a read's wait cycles and steps by one between reads, that done is a single-cycle pulse, and that a misaligned word request completes with an error on the next cycle. Which bytes arrive in which lanes, the device read count for each width and size, the shifted first address, and the total latency can only be shown by the bench scenarios. These run against a byte-patterned memory model across all three widths, the reserved width code and several wait settings.

// File: rtl/stmem_pkg.sv
`timescale 1ns/1ps
package stmem_pkg;
    typedef enum logic [1:0] {DW_8 = 2'b00, DW_16 = 2'b01, DW_32 = 2'b10, DW_RSV = 2'b11} dev_width_e;
    typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_HALF = 2'b01, SZ_WORD = 2'b10, SZ_RSV = 2'b11} req_size_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FINISH} state_e;
endpackage

// File: rtl/stmem_bank_decode.sv
`timescale 1ns/1ps
module stmem_bank_decode
    import stmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BANK_LSB  = 27,
    parameter int BANK_BITS = 3,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           size,
    input  logic [2*NBANK-1:0]   cfg_width,
    output logic [BANK_BITS-1:0] bank,
    output dev_width_e           width,
    output logic [2:0]           beats,
    output logic                 misalign
);
    logic [1:0] raw_width;

    always_comb begin
        bank      = addr[BANK_LSB +: BANK_BITS];
        raw_width = cfg_width[2*bank +: 2];
        // reserved code falls back to the widest path
        width     = (raw_width == DW_RSV) ? DW_32 : dev_width_e'(raw_width);

        unique case (width)
            DW_8: begin
                unique case (req_size_e'(size))
                    SZ_HALF: beats = 3'd2;
                    SZ_WORD: beats = 3'd4;
                    default: beats = 3'd1;
                endcase
            end
            DW_16:   beats = (req_size_e'(size) == SZ_WORD) ? 3'd2 : 3'd1;
            default: beats = 3'd1;
        endcase

        misalign = (req_size_e'(size) == SZ_RSV)
                || ((req_size_e'(size) == SZ_HALF) && addr[0])
                || ((req_size_e'(size) == SZ_WORD) && (addr[1:0] != 2'b00));
    end
endmodule

// File: rtl/stmem_lane_pack.sv
`timescale 1ns/1ps
module stmem_lane_pack
    import stmem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] rdata,
    input  dev_width_e        width,
    input  logic [1:0]        beat,
    input  logic [1:0]        lane,
    output logic [DATA_W-1:0] acc_d
);
    always_comb begin
        acc_d = acc_q;
        unique case (width)
            DW_8:  acc_d[8*beat +: 8] = rdata[7:0];
            DW_16: acc_d[16*beat[0] +: 16] = lane[0] ? {8'h00, rdata[15:8]} : rdata[15:0];
            default: acc_d = rdata >> (8*lane);
        endcase
    end
endmodule

// File: rtl/stmem_read_ctrl.sv
`timescale 1ns/1ps
module stmem_read_ctrl
    import stmem_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 3,
    parameter int DEV_AW    = 27,
    parameter int WAIT_W    = 3,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [2*NBANK-1:0]   cfg_width,
    input  logic [WAIT_W-1:0]    cfg_wait,
    output logic                 rsp_done,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [NBANK-1:0]     mem_cs_n,
    output logic                 mem_oe_n,
    output logic [DEV_AW-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rdata
);
    state_e                state_q, state_d;
    logic [BANK_BITS-1:0]  bank_q, dec_bank;
    dev_width_e            width_q, dec_width;
    logic [1:0]            size_q, lane_q, beat_q;
    logic [2:0]            beats_q, dec_beats;
    logic [WAIT_W-1:0]     wait_q, wait_cfg_q;
    logic [DEV_AW-1:0]     base_q, dec_base;
    logic [DATA_W-1:0]     acc_q, acc_d;
    logic                  err_q, dec_misalign;
    logic                  slot_end, last_beat;

    stmem_bank_decode #(
        .ADDR_W(ADDR_W), .BANK_LSB(DEV_AW), .BANK_BITS(BANK_BITS)
    ) u_decode (
        .addr(req_addr), .size(req_size), .cfg_width(cfg_width),
        .bank(dec_bank), .width(dec_width), .beats(dec_beats), .misalign(dec_misalign)
    );

    stmem_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .acc_q(acc_q), .rdata(mem_rdata), .width(width_q),
        .beat(beat_q), .lane(lane_q), .acc_d(acc_d)
    );

    // device word address: drop the byte-lane bits of the in-bank address
    always_comb begin
        unique case (dec_width)
            DW_8:    dec_base = req_addr[DEV_AW-1:0];
            DW_16:   dec_base = req_addr[DEV_AW-1:0] >> 1;
            default: dec_base = req_addr[DEV_AW-1:0] >> 2;
        endcase
    end

    assign slot_end  = (wait_q == wait_cfg_q);
    assign last_beat = ({1'b0, beat_q} == (beats_q - 3'd1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec_misalign ? ST_FINISH : ST_ACCESS;
            ST_ACCESS: if (slot_end && last_beat) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bank_q     <= '0;
            width_q    <= DW_8;
            size_q     <= '0;
            lane_q     <= '0;
            beat_q     <= '0;
            beats_q    <= 3'd1;
            wait_q     <= '0;
            wait_cfg_q <= '0;
            base_q     <= '0;
            acc_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                bank_q     <= dec_bank;
                width_q    <= dec_width;
                size_q     <= req_size;
                lane_q     <= req_addr[1:0];
                beats_q    <= dec_beats;
                wait_cfg_q <= cfg_wait;
                base_q     <= dec_base;
                err_q      <= dec_misalign;
                beat_q     <= '0;
                wait_q     <= '0;
                acc_q      <= '0;
            end else if (state_q == ST_ACCESS) begin
                if (slot_end) begin
                    acc_q  <= acc_d;
                    beat_q <= beat_q + 2'd1;
                    wait_q <= '0;
                end else begin
                    wait_q <= wait_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_cs_n = '1;
        mem_oe_n = 1'b1;
        rsp_done = 1'b0;
        rsp_err  = 1'b0;
        rsp_data = '0;
        mem_addr = base_q + DEV_AW'(beat_q);
        unique case (state_q)
            ST_ACCESS: begin
                mem_cs_n[bank_q] = 1'b0;
                mem_oe_n         = 1'b0;
            end
            ST_FINISH: begin
                rsp_done = 1'b1;
                rsp_err  = err_q;
                if (!err_q) begin
                    unique case (req_size_e'(size_q))
                        SZ_BYTE: rsp_data = acc_q & DATA_W'(32'h0000_00FF);
                        SZ_HALF: rsp_data = acc_q & DATA_W'(32'h0000_FFFF);
                        default: rsp_data = acc_q;
                    endcase
                end
            end
            default: ;
        endcase
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R2
    AST_OE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (mem_cs_n != '1)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n && wait_q != '0) |-> $stable(mem_addr)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n && beat_q != 2'd0 && wait_q == '0) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R4
    AST_MISALIGN_FAST: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && req_valid && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> (rsp_done && rsp_err && mem_oe_n)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done); // R10
endmodule

// File: tb/test_stmem_read_ctrl.sv
`timescale 1ns/1ps
module test_stmem_read_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [15:0] cfg_width;
    logic [2:0]  cfg_wait = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_data, mem_rdata;
    logic [7:0]  mem_cs_n;
    logic        mem_oe_n;
    logic [26:0] mem_addr;

    int tests = 0, fails = 0;
    int act_cnt, cs_bad, cur_bank;
    logic [26:0] first_addr;

    // bank widths: 0:8 1:16 2:32 3:reserved(->32) 4..7:8
    assign cfg_width = {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};

    always #4 clk = ~clk;

    stmem_read_ctrl i_stmem_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input int bank, input logic [26:0] a);
        return (a[7:0] * 8'd13 + 8'(bank * 37)) ^ a[15:8];
    endfunction

    function automatic int dev_bytes(input int bank);
        case (cfg_width[2*bank +: 2])
            2'b00: return 1;
            2'b01: return 2;
            default: return 4;
        endcase
    endfunction

    // device model: bytes beyond the device width carry filler
    always_comb begin
        int bk, nb;
        bk = 0;
        for (int k = 0; k < 8; k++) if (!mem_cs_n[k]) bk = k;
        nb = dev_bytes(bk);
        mem_rdata = 32'hEEEE_EEEE;
        if (!mem_oe_n)
            for (int j = 0; j < 4; j++)
                if (j < nb) mem_rdata[8*j +: 8] = pat(bk, 27'(mem_addr * nb + j));
    end

    always @(negedge clk) begin
        if (!mem_oe_n) begin
            if (act_cnt == 0) first_addr = mem_addr;
            act_cnt++;
            if (mem_cs_n != ~(8'b1 << cur_bank)) cs_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input int bank, input logic [26:0] off, input logic [1:0] size,
                           input logic [2:0] wt, input string req);
        int nb, bytes, beats, lat, exp_lat;
        bit bad;
        logic [31:0] exp;
        nb    = dev_bytes(bank);
        bytes = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
        bad   = (size == 2'b11) || (size == 2'b01 && off[0]) || (size == 2'b10 && off[1:0] != 0);
        beats = (bytes > nb) ? bytes / nb : 1;
        exp = '0;
        if (!bad) for (int i = 0; i < bytes; i++) exp[8*i +: 8] = pat(bank, off + 27'(i));
        exp_lat = bad ? 1 : beats * (wt + 1) + 1;
        cur_bank = bank; act_cnt = 0; cs_bad = 0;
        @(negedge clk);
        req_addr = {2'b00, 3'(bank), off}; req_size = size; cfg_wait = wt; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
        end
        chk(lat == exp_lat, "R10", "latency", lat, exp_lat);
        chk(rsp_err == bad, "R9", "error flag", rsp_err, bad);
        chk(rsp_data == exp, req, "read data", rsp_data, exp);
        chk(act_cnt == (bad ? 0 : beats * (wt + 1)), "R4", "active cycles", act_cnt, bad ? 0 : beats * (wt + 1));
        chk(cs_bad == 0, "R2", "chip-select pattern", cs_bad, 0);
        if (!bad) chk(first_addr == off / nb, "R3", "first device address", first_addr, off / nb);
        @(posedge clk); @(negedge clk);
        chk(!rsp_done, "R10", "done width", rsp_done, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(mem_cs_n == 8'hFF && mem_oe_n && !rsp_done && !rsp_err, "R1", "reset outputs",
            {mem_cs_n, 6'd0, mem_oe_n, rsp_done, 15'd0, rsp_err}, {8'hFF, 6'd0, 1'b1, 1'b0, 15'd0, 1'b0});
    endtask

    task automatic t_byte_lanes;
        do_read(0, 27'd3, 2'b00, 3'd0, "R3");
        do_read(1, 27'd3, 2'b00, 3'd2, "R6");
        do_read(1, 27'd10, 2'b00, 3'd1, "R6");
        do_read(2, 27'd7, 2'b00, 3'd0, "R6");
        do_read(2, 27'd4, 2'b00, 3'd1, "R6");
    endtask

    task automatic t_words;
        do_read(0, 27'd4, 2'b10, 3'd0, "R7");
        do_read(1, 27'd8, 2'b10, 3'd3, "R7");
        do_read(2, 27'h100, 2'b10, 3'd7, "R5");
        do_read(0, 27'h7FFFFFC, 2'b10, 3'd1, "R4");
    endtask

    task automatic t_halves;
        do_read(0, 27'd6, 2'b01, 3'd0, "R8");
        do_read(1, 27'd2, 2'b01, 3'd1, "R8");
        do_read(2, 27'd6, 2'b01, 3'd0, "R8");
    endtask

    task automatic t_misaligned;
        do_read(2, 27'd2, 2'b10, 3'd3, "R9");
        do_read(1, 27'd1, 2'b01, 3'd3, "R9");
        do_read(0, 27'd0, 2'b11, 3'd3, "R9");
    endtask

    task automatic t_banks;
        do_read(3, 27'd5, 2'b00, 3'd0, "R2");
        do_read(3, 27'd12, 2'b10, 3'd0, "R2");
        do_read(5, 27'd9, 2'b10 & 2'b00, 3'd0, "R2");
        do_read(7, 27'd20, 2'b10, 3'd0, "R2");
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        act_cnt = 0; cs_bad = 0; cur_bank = 0; first_addr = '0;
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_byte_lanes();
        t_words();
        t_halves();
        t_misaligned();
        t_banks();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule